// File: doc/BRIEF.md
# Leveled Priority Interrupt Arbiter

This block gathers interrupt requests from a parameterised number of sources and forwards a single request to a processor core. A source's input line is live only while its peripheral flag and its enable bit are both high. Software sets a three-bit level for each source. Level 0 turns the source off, and levels 1 to 7 rank it. On every clock the block picks one winner from the sources that are eligible. The highest level wins, and when levels are equal the lowest source index wins. The block then registers three outputs for the core: a request, the winner's level, and the winner's vector number. The vector number is fixed in hardware as `VEC_BASE` plus the source index.

Sources that lose arbitration stay pending and are presented later. If a stronger source arrives before the core acknowledges the current request, the outputs move to that source. When the core acknowledges, the block masks the source it is presenting. The mask stays until that source's line goes low, so the same flag is never presented twice. A small write port loads the level registers.

A two-state controller drives the outputs. The states are `ST_IDLE` (no request) and `ST_PRESENT` (request asserted). The transitions are named as follows:
- `IDLE->PRESENT` happens when some source is eligible.
- `PRESENT->PRESENT` holds the request and retargets it to the current winner.
- `PRESENT->IDLE` happens when no source is eligible.
- `IDLE->IDLE` happens otherwise.

Top module: `lvl_arb_top`

## Requirements
- R1: After reset every level register is 0, `irq_o` is 0, and `irq_lvl_o` and `irq_vec_o` are 0.
- R2: A write with `wr_en_i` high loads `wr_lvl_i` into the level of source `wr_addr_i`. The new level takes part in arbitration from the next cycle. A write whose address is N or above changes nothing.
- R3: A source whose level is 0 is never presented. Whenever `irq_o` is 1, `irq_lvl_o` is nonzero.
- R4: Among eligible sources, the one with the highest level is presented.
- R5: Among eligible sources that share the highest level, the one with the lowest index is presented.
- R6: While `irq_o` is 1, `irq_vec_o` equals `VEC_BASE` plus the winner's index, and `irq_lvl_o` equals the winner's level. While `irq_o` is 0, both are 0.
- R7: Outputs reflect the inputs of the previous cycle, through one register stage. `irq_o` stays 1 in every cycle that follows a cycle in which at least one source was eligible.
- R8: If a stronger source becomes eligible before the acknowledge, the level and vector outputs switch to it. The displaced source stays pending and is presented once the stronger ones are gone.
- R9: A source whose line drops before it is accepted is no longer presented. If no line is live, `irq_o` is 0 in the next cycle.
- R10: A flag whose enable bit is 0 never causes a request.
- R11: When `ack_i` is 1 while `irq_o` is 1, the presented source is masked from the next cycle on. The mask lasts until its line is seen low, after which the source may be presented again.
- R12: `ack_i` has no effect while `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flag_i | input | N | Peripheral flag per source |
| en_i | input | N | Interrupt enable per source |
| ack_i | input | 1 | Acknowledge from the core |
| wr_en_i | input | 1 | Level write strobe |
| wr_addr_i | input | IDX_W | Source index for a level write |
| wr_lvl_i | input | 3 | Level value to write |
| irq_o | output | 1 | Request to the core |
| irq_lvl_o | output | 3 | Level of the presented source |
| irq_vec_o | output | VEC_W | Vector number of the presented source |

## Verification
The bench builds the block with N = 6, VEC_BASE = 5 and VEC_W = 5. Because six sources fit in a three-bit address, the addresses 6 and 7 exist, so out-of-range level writes can be exercised. The nonzero base also shows that the vector output is offset and not the raw index. With only six sources, random flags, levels and acknowledges produce frequent ties, retargets and re-raised masked lines. Directed sequences cover level-0 suppression, retargeting before acknowledge, and acknowledges that arrive while idle.

// File: rtl/lvl_arb_pkg.sv
package lvl_arb_pkg;
    localparam int LVL_W = 3;
    typedef logic [LVL_W-1:0] lvl_t;
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } arb_state_e;
endpackage

// File: rtl/lvl_arb_regs.sv
module lvl_arb_regs
    import lvl_arb_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [IDX_W-1:0]        wr_addr_i,
    input  lvl_t                    wr_lvl_i,
    output logic [N-1:0][LVL_W-1:0] lvl_o
);
    for (genvar g = 0; g < N; g++) begin : g_src
        logic sel;
        assign sel = wr_en_i && (int'(wr_addr_i) == g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lvl_o[g] <= '0;
            end else if (sel) begin
                lvl_o[g] <= wr_lvl_i;
            end
        end
    end
endmodule

// File: rtl/lvl_arb_mask.sv
module lvl_arb_mask #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_i,
    input  logic [N-1:0] take_i,
    output logic [N-1:0] mask_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_o[g] <= 1'b0;
            end else if (take_i[g]) begin
                mask_o[g] <= 1'b1;
            end else if (!line_i[g]) begin
                mask_o[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lvl_arb_pick.sv
module lvl_arb_pick
    import lvl_arb_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]            elig_i,
    input  logic [N-1:0][LVL_W-1:0] lvl_i,
    output logic                    found_o,
    output logic [IDX_W-1:0]        idx_o,
    output lvl_t                    lvl_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        lvl_o   = '0;
        for (int i = 0; i < N; i++) begin
            if (elig_i[i] && (lvl_i[i] > lvl_o)) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
                lvl_o   = lvl_i[i];
            end
        end
    end
endmodule

// File: rtl/lvl_arb_top.sv
module lvl_arb_top
    import lvl_arb_pkg::*;
#(
    parameter int N        = 8,
    parameter int VEC_BASE = 4,
    parameter int VEC_W    = 5,
    localparam int IDX_W   = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     flag_i,
    input  logic [N-1:0]     en_i,
    input  logic             ack_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_addr_i,
    input  logic [2:0]       wr_lvl_i,
    output logic             irq_o,
    output logic [2:0]       irq_lvl_o,
    output logic [VEC_W-1:0] irq_vec_o
);
    arb_state_e              state_q, state_d;
    logic [N-1:0][LVL_W-1:0] lvl_tab;
    logic [N-1:0]            line, mask, take, elig;
    logic [IDX_W-1:0]        cur_idx_q, win_idx;
    lvl_t                    win_lvl;
    logic                    found, ack_take;

    assign line     = flag_i & en_i;
    assign ack_take = ack_i && (state_q == ST_PRESENT);

    for (genvar g = 0; g < N; g++) begin : g_take
        assign take[g] = ack_take && (int'(cur_idx_q) == g);
    end

    assign elig = line & ~mask & ~take;

    lvl_arb_regs #(.N(N), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_lvl_i(wr_lvl_i), .lvl_o(lvl_tab)
    );

    lvl_arb_mask #(.N(N)) u_mask (
        .clk(clk), .rst_n(rst_n), .line_i(line), .take_i(take), .mask_o(mask)
    );

    lvl_arb_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .elig_i(elig), .lvl_i(lvl_tab), .found_o(found),
        .idx_o(win_idx), .lvl_o(win_lvl)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = found ? ST_PRESENT : ST_IDLE;
            ST_PRESENT: state_d = found ? ST_PRESENT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o     <= 1'b0;
            irq_lvl_o <= '0;
            irq_vec_o <= '0;
            cur_idx_q <= '0;
        end else begin
            unique case (state_d)
                ST_PRESENT: begin
                    irq_o     <= 1'b1;
                    irq_lvl_o <= win_lvl;
                    irq_vec_o <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
                    cur_idx_q <= win_idx;
                end
                default: begin
                    irq_o     <= 1'b0;
                    irq_lvl_o <= '0;
                    irq_vec_o <= '0;
                    cur_idx_q <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/lvl_arb_chk.sv
module lvl_arb_chk #(
    parameter int N        = 8,
    parameter int VEC_BASE = 4,
    parameter int VEC_W    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     flag_i,
    input logic [N-1:0]     en_i,
    input logic             ack_i,
    input logic             irq_o,
    input logic [2:0]       irq_lvl_o,
    input logic [VEC_W-1:0] irq_vec_o
);
    AST_LVL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_lvl_o != 3'd0)); // R3
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (irq_lvl_o == 3'd0 && irq_vec_o == '0)); // R6
    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (int'(irq_vec_o) >= VEC_BASE && int'(irq_vec_o) < VEC_BASE + N)); // R6
    AST_DROP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_i & en_i) == '0) |=> !irq_o); // R9
    AST_ACK_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && ack_i) |=> !(irq_o && irq_vec_o == $past(irq_vec_o))); // R11
endmodule

bind lvl_arb_top lvl_arb_chk #(.N(N), .VEC_BASE(VEC_BASE), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .flag_i(flag_i), .en_i(en_i), .ack_i(ack_i),
    .irq_o(irq_o), .irq_lvl_o(irq_lvl_o), .irq_vec_o(irq_vec_o)
);

// File: tb/sim_lvl_arb_top.sv
`timescale 1ns/1ps
module sim_lvl_arb_top;
    localparam int N = 6;
    localparam int VB = 5;
    localparam int VW = 5;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  flag_i = '0, en_i = '0;
    logic          ack_i = 1'b0, wr_en_i = 1'b0;
    logic [AW-1:0] wr_addr_i = '0;
    logic [2:0]    wr_lvl_i = '0;
    logic          irq_o;
    logic [2:0]    irq_lvl_o;
    logic [VW-1:0] irq_vec_o;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [2:0]    m_lvl [N];
    logic [N-1:0]  m_mask = '0;
    logic          m_irq = 0;
    logic [2:0]    m_olvl = 0;
    logic [VW-1:0] m_vec = 0;

    always #2 clk = ~clk;

    lvl_arb_top #(.N(N), .VEC_BASE(VB), .VEC_W(VW)) u0 (
        .clk(clk), .rst_n(rst_n), .flag_i(flag_i), .en_i(en_i), .ack_i(ack_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_lvl_i(wr_lvl_i),
        .irq_o(irq_o), .irq_lvl_o(irq_lvl_o), .irq_vec_o(irq_vec_o)
    );

    task automatic check(input string tag);
        checks++;
        if (irq_o !== m_irq || irq_lvl_o !== m_olvl || irq_vec_o !== m_vec) begin
            fails++;
            $display("FAIL %s: got irq=%0b lvl=%0d vec=%0d, expected irq=%0b lvl=%0d vec=%0d",
                     tag, irq_o, irq_lvl_o, irq_vec_o, m_irq, m_olvl, m_vec);
        end
    endtask

    // Apply the current inputs for one clock: update the model, then compare.
    task automatic step(input string tag);
        logic [N-1:0] line, tk;
        logic [2:0]   bl;
        int           bi;
        bit           f;
        line = flag_i & en_i;
        tk = '0;
        if (ack_i && m_irq) tk[int'(m_vec) - VB] = 1'b1;
        bl = 0; bi = 0; f = 0;
        for (int i = 0; i < N; i++)
            if (line[i] && !m_mask[i] && !tk[i] && m_lvl[i] > bl) begin
                bl = m_lvl[i]; bi = i; f = 1;
            end
        for (int i = 0; i < N; i++)
            m_mask[i] = tk[i] ? 1'b1 : (line[i] ? m_mask[i] : 1'b0);
        if (wr_en_i && int'(wr_addr_i) < N) m_lvl[int'(wr_addr_i)] = wr_lvl_i;
        m_irq = f;
        m_olvl = f ? bl : 3'd0;
        m_vec = f ? VW'(VB + bi) : '0;
        @(posedge clk); #1;
        check(tag);
    endtask

    task automatic wr(input int a, input int l, input string tag);
        wr_en_i = 1; wr_addr_i = AW'(a); wr_lvl_i = 3'(l);
        step(tag);
        wr_en_i = 0;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) m_lvl[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #1 check("R1 reset state");
        // R3: all sources flagged but every level is still 0
        flag_i = '1; en_i = '1;
        step("R3 level0 suppressed"); step("R3 level0 suppressed");
        flag_i = '0;
        wr(2, 3, "R2 write"); wr(4, 3, "R2 write");
        // R5 tie at level 3: source 2 wins
        flag_i = 6'b010100;
        step("R5 tie"); step("R5 tie hold R7");
        // R8 retarget: source 5 at level 6
        wr(5, 6, "R2 write");
        flag_i = 6'b110100;
        step("R8 retarget"); step("R4 highest");
        // R11 acknowledge masks source 5, then source 2 is presented (R8 held)
        ack_i = 1; step("R11 ack"); ack_i = 0;
        step("R8 held presented");
        step("R11 still masked");
        // R11 drop source 5 line, re-raise: presented again
        flag_i = 6'b010100; step("R11 line low");
        flag_i = 6'b110100; step("R11 re-raise"); step("R11 re-present");
        // R2 out-of-range writes do nothing
        wr(6, 7, "R2 out of range"); wr(7, 7, "R2 out of range");
        step("R2 no change");
        // R10 flag without enable
        flag_i = 6'b100000; en_i = 6'b011111;
        step("R10 enable gate"); step("R10 enable gate");
        // R9 drop line before acceptance
        en_i = '1; flag_i = 6'b000100; step("R9 pending");
        flag_i = '0; step("R9 dropped"); step("R9 idle");
        // R12 ack while idle is ignored
        ack_i = 1; step("R12 ack idle"); ack_i = 0;
        flag_i = 6'b000100; step("R12 not masked"); step("R12 presented");
        flag_i = '0; step("R7 idle");
        // Random phase
        for (int k = 0; k < 3000; k++) begin
            flag_i = N'($urandom);
            en_i = N'($urandom | $urandom);
            ack_i = ($urandom_range(3) == 0);
            wr_en_i = ($urandom_range(7) == 0);
            wr_addr_i = AW'($urandom);
            wr_lvl_i = 3'($urandom);
            step("R4 R5 R6 R8 R11 random");
        end
        wr_en_i = 0; ack_i = 0;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule